// File: doc/BRIEF.md
# Serial-by-parallel signed multiplier

The block forms the 2W-bit two's complement product of two W-bit signed operands. One operand arrives as a parallel word, captured in the cycle that `start_i` is high. The other arrives one bit per cycle on `x_i`, least significant bit first, beginning in that same cycle. The product leaves one bit per cycle on `prod_o`, also least significant bit first. It is framed by `valid_o`, and `lsb_o` marks its first bit.

The datapath is a chain of 2W identical cells, one for each bit of the sign-extended parallel operand. Each cell has an AND gate that forms the partial-product bit and an XOR gate that can complement it. It also has a full adder whose carry is kept in the cell and whose sum is registered and passed one cell down the chain. The lowest cell's sum register drives the product output.

A small sequencer counts the serial bits. It stops the serial input from taking part once W bits have been seen. In the cycle of the serial sign bit it complements every partial-product bit. Together with a unit carry preset into the cell of weight W-1, this subtracts the sign row, so the result is correct two's complement. A new `start_i` clears the chain's stored sums and carries, so operations can follow each other with no idle cycles.

Top module: `serial_signed_mul`

## Requirements
- R1: The 2W bits on `prod_o`, taken LSB first, equal the two's complement product of the parallel operand and the W serial bits, interpreted as a signed 2W-bit value.
- R2: The product LSB appears on `prod_o` two cycles after the cycle in which `start_i` is high. The following bits appear one per cycle, so one operation spans 2W+2 cycles.
- R3: `valid_o` is high for exactly the 2W cycles that carry product bits. `lsb_o` is high only together with the first of them.
- R4: A new `start_i` issued 2W cycles after the previous one produces its product immediately after the previous product, with no gap and no corruption.
- R5: Values on `x_i` in cycles W to 2W-1 of an operation, and while idle, have no effect on any product.
- R6: `y_i` is sampled only in the `start_i` cycle; changes to it in later cycles have no effect on the product in flight.
- R7: Extreme operands are exact, including the most negative value times itself (result 2^(2W-2)) and the most negative value times the most positive.
- R8: A `start_i` during an operation abandons it. The two bits already in the output pipeline still appear, and then the new product follows in full.
- R9: While `rst_ni` is low, `prod_o`, `valid_o` and `lsb_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begins an operation; `x_i` carries serial bit 0 in this cycle |
| x_i | input | 1 | Serial signed operand, LSB first |
| y_i | input | W | Parallel signed operand, sampled with `start_i` |
| prod_o | output | 1 | Serial product bit, LSB first |
| valid_o | output | 1 | `prod_o` carries a product bit |
| lsb_o | output | 1 | `prod_o` carries the product LSB |

## Verification
The bench builds the block with W = 16, which means 32 cells and 34-cycle operations. At this width the values -32768, 32767 and -1 can be driven directly, so the sign-row correction and the preset carry are exercised where they matter most. The bench runs operations back to back, abandons one after ten cycles, and leaves a longer idle gap. Throughout, it drives random values on `x_i` after the sixteenth bit and on `y_i` outside start cycles.

// File: rtl/ssm_pkg.sv
package ssm_pkg;
  localparam int unsigned SSM_OP_W = 16;

  typedef struct packed {
    logic act;  // operation in flight
    logic clr;  // first bit of an operation: discard chain state
    logic inv;  // sign row: complement partial products
    logic x;    // gated serial bit
  } ssm_ctrl_t;
endpackage

// File: rtl/ssm_seq.sv
module ssm_seq
  import ssm_pkg::*;
#(
  parameter int unsigned W = SSM_OP_W
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      start_i,
  input  logic      x_i,
  output ssm_ctrl_t ctrl_o
);
  localparam int unsigned PW = 2 * W;
  localparam int unsigned CW = $clog2(PW);

  logic [CW-1:0] cnt_q;
  logic          act_q;
  logic          x_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      act_q <= 1'b0;
      x_q   <= 1'b0;
    end else begin
      x_q <= x_i;
      if (start_i) begin
        cnt_q <= '0;
        act_q <= 1'b1;
      end else if (act_q) begin
        if (cnt_q == CW'(PW - 1)) act_q <= 1'b0;
        else                      cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  always_comb begin
    ctrl_o.act = act_q;
    ctrl_o.clr = act_q && (cnt_q == '0);
    ctrl_o.inv = act_q && (cnt_q == CW'(W - 1));
    ctrl_o.x   = act_q && (cnt_q < CW'(W)) && x_q;
  end

  // R8: a start always re-arms the count, even mid-operation
  a_r8_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (act_q && cnt_q == '0));

  // R3: the operation ends after 2W bits
  a_r3_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q && cnt_q == CW'(PW - 1) && !start_i) |=> !act_q);
endmodule

// File: rtl/ssm_cell.sv
module ssm_cell #(
  parameter bit CINIT = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic x_i,
  input  logic y_i,
  input  logic inv_i,
  input  logic clr_i,
  input  logic s_i,
  output logic s_o
);
  logic pp, b, c, sum, cout;
  logic s_q, c_q;

  always_comb begin
    pp   = (x_i & y_i) ^ inv_i;
    b    = clr_i ? 1'b0  : s_i;
    c    = clr_i ? CINIT : c_q;
    sum  = pp ^ b ^ c;
    cout = (pp & b) | (pp & c) | (b & c);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s_q <= 1'b0;
      c_q <= 1'b0;
    end else begin
      s_q <= sum;
      c_q <= cout;
    end
  end

  assign s_o = s_q;

  // R1: clearing discards old state and leaves only the preset carry
  a_r1_cell_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !inv_i && !(x_i && y_i)) |=> (s_q == CINIT && !c_q));
endmodule

// File: rtl/serial_signed_mul.sv
module serial_signed_mul
  import ssm_pkg::*;
#(
  parameter int unsigned W = SSM_OP_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         x_i,
  input  logic [W-1:0] y_i,
  output logic         prod_o,
  output logic         valid_o,
  output logic         lsb_o
);
  localparam int unsigned PW = 2 * W;

  ssm_ctrl_t      ctrl;
  logic [W-1:0]   y_q;
  logic [PW-1:0]  y_ext;
  logic [PW:0]    s_chain;
  logic           valid_q, lsb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      y_q <= '0;
    else if (start_i) y_q <= y_i;
  end

  assign y_ext       = {{W{y_q[W-1]}}, y_q};
  assign s_chain[PW] = 1'b0;

  ssm_seq #(.W(W)) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .x_i    (x_i),
    .ctrl_o (ctrl)
  );

  // Cell j weighs y_ext[j]; cell W-1 presets the +1 of the sign-row negation
  for (genvar j = 0; j < PW; j++) begin : g_cell
    ssm_cell #(.CINIT(j == W - 1)) u_cell (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .x_i   (ctrl.x),
      .y_i   (y_ext[j]),
      .inv_i (ctrl.inv),
      .clr_i (ctrl.clr),
      .s_i   (s_chain[j+1]),
      .s_o   (s_chain[j])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      lsb_q   <= 1'b0;
    end else begin
      valid_q <= ctrl.act;
      lsb_q   <= ctrl.clr;
    end
  end

  assign prod_o  = s_chain[0];
  assign valid_o = valid_q;
  assign lsb_o   = lsb_q;

  a_r2_lsb_delay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> ##2 (lsb_o && valid_o));

  a_r3_valid_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> lsb_o);

  a_r3_lsb_in_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lsb_o |-> valid_o);
endmodule

// File: tb/serial_signed_mul_bench.sv
module serial_signed_mul_bench;
  localparam int unsigned W     = 16;
  localparam int unsigned PW    = 2 * W;
  localparam time         CLK_P = 10;

  logic         clk_i = 1'b0;
  logic         rst_ni;
  logic         start_i;
  logic         x_i;
  logic [W-1:0] y_i;
  logic         prod_o, valid_o, lsb_o;

  serial_signed_mul #(.W(W)) u_serial_signed_mul (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .x_i    (x_i),
    .y_i    (y_i),
    .prod_o (prod_o),
    .valid_o(valid_o),
    .lsb_o  (lsb_o)
  );

  always #(CLK_P / 2) clk_i = ~clk_i;

  typedef struct {
    logic  b;
    logic  l;
    string tag;
  } exp_t;

  exp_t   sb_q[$];
  longint start_cyc[$];
  longint cyc = 0;
  int     n_chk = 0;
  int     n_fail = 0;
  bit     done = 1'b0;

  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Driver: one operation of ncyc cycles; random x after W bits, random y after start
  task automatic drive_op(input logic signed [W-1:0] x, input logic signed [W-1:0] y,
                          input int ncyc, input string tag);
    longint p;
    exp_t   e;
    p = longint'(x) * longint'(y);
    @(negedge clk_i);
    // R8: only the two bits already in the output pipeline survive a new start
    while (sb_q.size() > 2) void'(sb_q.pop_back());
    for (int i = 0; i < PW; i++) begin
      e.b = p[i];
      e.l = (i == 0);
      e.tag = tag;
      sb_q.push_back(e);
    end
    start_cyc.push_back(cyc);
    for (int c = 0; c < ncyc; c++) begin
      if (c > 0) @(negedge clk_i);
      start_i = (c == 0);
      x_i     = (c < int'(W)) ? x[c] : 1'($urandom);
      y_i     = (c == 0) ? y : W'($urandom);
    end
  endtask

  task automatic idle(input int n);
    for (int c = 0; c < n; c++) begin
      @(negedge clk_i);
      start_i = 1'b0;
      x_i     = 1'($urandom);
      y_i     = W'($urandom);
    end
  endtask

  // Monitor
  initial begin
    exp_t   e;
    longint s;
    forever begin
      @(negedge clk_i);
      #1;
      if (rst_ni && valid_o) begin
        if (sb_q.size() == 0) begin
          chk(1'b0, "R3", "valid_o with nothing expected", 1, 0);
        end else begin
          e = sb_q.pop_front();
          chk(prod_o == e.b, e.tag, "product bit", prod_o, e.b);
          chk(lsb_o == e.l, "R3", "lsb_o marker", lsb_o, e.l);
        end
        if (lsb_o && start_cyc.size() > 0) begin
          s = start_cyc.pop_front();
          chk(cyc - s == 2, "R2", "cycles from start to LSB", cyc - s, 2);
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_ni  = 1'b0;
    start_i = 1'b0;
    x_i     = 1'b0;
    y_i     = '0;
    repeat (3) @(negedge clk_i);
    chk(prod_o == 1'b0, "R9", "prod_o in reset", prod_o, 0);
    chk(valid_o == 1'b0, "R9", "valid_o in reset", valid_o, 0);
    chk(lsb_o == 1'b0, "R9", "lsb_o in reset", lsb_o, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    idle(3);

    drive_op(16'sd3, 16'sd5, PW, "R1");
    drive_op(-16'sd1, -16'sd1, PW, "R4");
    drive_op(16'sh1234, -16'sd7, PW, "R6");
    drive_op(-16'sd32768, -16'sd32768, PW, "R7");
    drive_op(16'sd32767, -16'sd32768, PW, "R7");
    drive_op(-16'sd32768, 16'sd32767, PW + 8, "R5");
    drive_op(16'sd12345, 16'sd321, 10, "R8");
    drive_op(-16'sd200, 16'sd77, PW, "R8");
    drive_op(16'sd0, -16'sd32768, PW, "R1");
    for (int k = 0; k < 8; k++)
      drive_op(W'($urandom), W'($urandom), PW, "R1");
    idle(PW + 8);

    chk(sb_q.size() == 0, "R3", "bits still owed", sb_q.size(), 0);
    chk(valid_o == 1'b0, "R3", "valid_o when idle", valid_o, 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule